// File: doc/BRIEF.md
# Width-Configurable Serial Data FIFO with Level Monitor

This block is a synchronous first-in first-out buffer that holds serial-link data words in one direction. It can sit between a shift engine and a host in either direction, so one copy is used for outgoing words and a second copy for incoming words. Its storage is a fixed pool of 256 bytes. A run-time width selector chooses whether each entry is one, two or four bytes, so the number of entries the pool holds changes with the width.

The buffer runs only after a start command. A command port takes a two-bit code: one bit empties the buffer and the other sets whether it runs. A status word reports the fill level together with full and empty flags. A programmable threshold gives a one-cycle event when the fill level rises to meet it. Three six-bit watermark fields are compared against the fill amount in four-byte units and drive three level flags. A write into a full buffer and a read from an empty one are both refused, and each is reported by a one-cycle strobe.

Top module: `spi_word_fifo`

## Requirements
- R1: The depth in entries is 256, 128 or 64 when `width_sel` is 0 (byte), 1 (halfword) or 2 (word); code 3 behaves as code 2. The buffer is full once that many entries are held.
- R2: Reads return the accepted entries in write order. An entry keeps the low 8, 16 or 32 bits of `wr_data` for the byte, halfword or word width, and the bits of `rd_data` above the entry width read as zero.
- R3: A write while full is dropped. The stored entries and the level do not change, and `overflow` is high for the one cycle after that clock edge.
- R4: A read while empty leaves `rd_data` at its previous value, and `underflow` is high for the one cycle after that clock edge.
- R5: When `op_wr` is high, bit 0 of `op_cmd` empties the buffer and bit 1 is loaded as the run state. Code 2 starts the buffer without losing its contents, and code 0 stops it.
- R6: While stopped, writes and reads have no effect: the level and contents hold, and neither `overflow` nor `underflow` is raised.
- R7: `status` carries the level in entries (modulo 256) in bits 7:0, full in bit 8 and empty in bit 9. Full and empty are never both set.
- R8: `thresh_evt` pulses for exactly one cycle when the level moves from below `thresh` to at least `thresh`.
- R9: With Q = (level × entry bytes) / 4, `wm_stop`, `wm_low` and `wm_high` are high exactly when Q ≥ `stop_cnt`, Q ≥ `low_cnt` and Q ≥ `high_cnt`.
- R10: An accepted read presents its data on `rd_data` in the cycle after the clock edge that takes it. An accepted write shows in `status` in the cycle after its edge.
- R11: After `rst_n` is released, the buffer is stopped and empty, `status` is 0x200 and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_wr | input | 1 | Command strobe |
| op_cmd | input | 2 | Command: bit 0 empties the buffer, bit 1 is the run state |
| width_sel | input | 2 | Entry width: 0 byte, 1 halfword, 2 or 3 word |
| thresh | input | 8 | Level threshold in entries |
| stop_cnt | input | 6 | Stop watermark in four-byte units |
| low_cnt | input | 6 | Low watermark in four-byte units |
| high_cnt | input | 6 | High watermark in four-byte units |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | 32 | Read data, registered |
| status | output | 10 | {empty, full, level[7:0]} |
| overflow | output | 1 | Dropped-write strobe |
| underflow | output | 1 | Empty-read strobe |
| thresh_evt | output | 1 | Threshold-reached pulse |
| wm_stop | output | 1 | Stop watermark reached |
| wm_low | output | 1 | Low watermark reached |
| wm_high | output | 1 | High watermark reached |

## Verification
The bench fills the buffer to exactly 256, 128 and 64 entries, and also uses width code 3. A design that sized the depth wrongly would raise full early or late, or would wrap its pointers into live data and break the scoreboard order. It writes past full and reads past empty. A design that still advanced its count, or that loaded stale memory into `rd_data`, would show a changed level or a changed read value. It stops the buffer while data is held and then restarts it with the run-only code. A design that let stopped traffic through, or that emptied the buffer on start, would lose or gain entries. It also counts threshold pulses across a full fill and checks watermark flags at fill amounts that land exactly on a field value, where an off-by-one comparison or a wrong byte-to-quad scaling would flip a flag.

// File: rtl/spf_pkg.sv
package spf_pkg;

  typedef enum logic [1:0] {
    SPF_BYTE     = 2'd0,
    SPF_HALF     = 2'd1,
    SPF_WORD     = 2'd2,
    SPF_WORD_ALT = 2'd3
  } spf_width_e;

  localparam int unsigned SPF_OP_CLR_BIT = 0;
  localparam int unsigned SPF_OP_RUN_BIT = 1;

  // log2 of the entry size in bytes
  function automatic logic [1:0] spf_shift(input logic [1:0] code);
    return (code == SPF_WORD_ALT) ? 2'd2 : code;
  endfunction

  // entries available in a pool of total_bytes at the given width
  function automatic int unsigned spf_depth(input int unsigned total_bytes,
                                            input logic [1:0] code);
    return total_bytes >> spf_shift(code);
  endfunction

  // fill amount in four-byte units
  function automatic int unsigned spf_quads(input int unsigned entries,
                                            input logic [1:0] code);
    return (entries << spf_shift(code)) >> 2;
  endfunction

  // number of byte lanes an entry occupies
  function automatic int unsigned spf_lanes(input logic [1:0] code);
    return 32'd1 << spf_shift(code);
  endfunction

endpackage

// File: rtl/spf_ctrl.sv
module spf_ctrl
  import spf_pkg::*;
#(
  parameter int unsigned TOTAL_BYTES = 256,
  localparam int unsigned PTR_W = $clog2(TOTAL_BYTES),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_wr,
  input  logic [1:0]       op_cmd,
  input  logic [1:0]       width_sel,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic             wr_acc,
  output logic             rd_acc,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             ovf_q,
  output logic             unf_q
);

  logic             running;
  logic             clr;
  logic [CNT_W-1:0] depth_c;
  logic [PTR_W-1:0] last_idx;
  logic             wr_drop;
  logic             rd_drop;

  assign depth_c  = CNT_W'(spf_depth(TOTAL_BYTES, width_sel));
  assign last_idx = PTR_W'(depth_c - 1'b1);
  assign clr      = op_wr && op_cmd[SPF_OP_CLR_BIT];

  assign full  = (count >= depth_c);
  assign empty = (count == '0);

  assign wr_acc  = running && wr_en && !full  && !clr;
  assign rd_acc  = running && rd_en && !empty && !clr;
  assign wr_drop = running && wr_en && full   && !clr;
  assign rd_drop = running && rd_en && empty  && !clr;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p,
                                            input logic [PTR_W-1:0] last);
    return (p >= last) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
    end else if (op_wr) begin
      running <= op_cmd[SPF_OP_RUN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_acc) wr_ptr <= step(wr_ptr, last_idx);
      if (rd_acc) rd_ptr <= step(rd_ptr, last_idx);
      case ({wr_acc, rd_acc})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= wr_drop;
      unf_q <= rd_drop;
    end
  end

  // R6: a stopped buffer does not move unless it is being emptied
  assert_stopped_holds_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !clr) |=> $stable(count));

  // R3: a full buffer with no read taken keeps its level
  assert_no_overflow_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_acc && !clr) |=> $stable(count));

  // R5: the empty command clears the level on the next cycle
  assert_clear_empties_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  // R7: full and empty flags exclude each other
  assert_flags_exclusive_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

endmodule

// File: rtl/spf_store.sv
module spf_store
  import spf_pkg::*;
#(
  parameter int unsigned TOTAL_BYTES = 256,
  parameter int unsigned DATA_W      = 32,
  localparam int unsigned PTR_W = $clog2(TOTAL_BYTES),
  localparam int unsigned LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        width_sel,
  input  logic              wr_acc,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_acc,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_data
);

  logic [7:0]        mem [TOTAL_BYTES];
  logic [1:0]        shift;
  int unsigned       lanes_on;
  logic [PTR_W-1:0]  wr_base;
  logic [PTR_W-1:0]  rd_base;
  logic [DATA_W-1:0] rd_word;

  assign shift    = spf_shift(width_sel);
  assign lanes_on = spf_lanes(width_sel);
  assign wr_base  = wr_ptr << shift;
  assign rd_base  = rd_ptr << shift;

  always_ff @(posedge clk) begin
    if (wr_acc) begin
      for (int l = 0; l < LANES; l++) begin
        if (l < lanes_on) mem[wr_base + PTR_W'(l)] <= wr_data[8*l +: 8];
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_word[8*g +: 8] = (g < lanes_on) ? mem[rd_base + PTR_W'(g)] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_acc) begin
      rd_data <= rd_word;
    end
  end

  // R4: without an accepted read the output word holds
  assert_underflow_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(rd_data));

endmodule

// File: rtl/spf_monitor.sv
module spf_monitor
  import spf_pkg::*;
#(
  parameter int unsigned CNT_W = 9,
  parameter int unsigned THR_W = 8,
  parameter int unsigned WM_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       width_sel,
  input  logic [THR_W-1:0] thresh,
  input  logic [WM_W-1:0]  stop_cnt,
  input  logic [WM_W-1:0]  low_cnt,
  input  logic [WM_W-1:0]  high_cnt,
  output logic             thr_evt,
  output logic             wm_stop,
  output logic             wm_low,
  output logic             wm_high
);

  localparam int unsigned Q_W = CNT_W + 1;

  logic [Q_W-1:0] quads;
  logic           above;
  logic           above_q;

  assign quads = Q_W'(spf_quads(32'(count), width_sel));
  assign above = (32'(count) >= 32'(thresh));

  assign wm_stop = (quads >= Q_W'(stop_cnt));
  assign wm_low  = (quads >= Q_W'(low_cnt));
  assign wm_high = (quads >= Q_W'(high_cnt));

  // start "above" so that no event fires out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) above_q <= 1'b1;
    else        above_q <= above;
  end

  assign thr_evt = above && !above_q;

  // R8: the event is a single-cycle pulse
  assert_evt_single_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    thr_evt |=> !thr_evt);

endmodule

// File: rtl/spi_word_fifo.sv
module spi_word_fifo
  import spf_pkg::*;
#(
  parameter int unsigned TOTAL_BYTES = 256,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned THR_W       = 8,
  parameter int unsigned WM_W        = 6,
  localparam int unsigned PTR_W = $clog2(TOTAL_BYTES),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_wr,
  input  logic [1:0]        op_cmd,
  input  logic [1:0]        width_sel,
  input  logic [THR_W-1:0]  thresh,
  input  logic [WM_W-1:0]   stop_cnt,
  input  logic [WM_W-1:0]   low_cnt,
  input  logic [WM_W-1:0]   high_cnt,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [PTR_W+1:0]  status,
  output logic              overflow,
  output logic              underflow,
  output logic              thresh_evt,
  output logic              wm_stop,
  output logic              wm_low,
  output logic              wm_high
);

  logic             wr_acc;
  logic             rd_acc;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] count;
  logic             full;
  logic             empty;

  spf_ctrl #(.TOTAL_BYTES(TOTAL_BYTES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_wr     (op_wr),
    .op_cmd    (op_cmd),
    .width_sel (width_sel),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wr_acc    (wr_acc),
    .rd_acc    (rd_acc),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .count     (count),
    .full      (full),
    .empty     (empty),
    .ovf_q     (overflow),
    .unf_q     (underflow)
  );

  spf_store #(.TOTAL_BYTES(TOTAL_BYTES), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .width_sel (width_sel),
    .wr_acc    (wr_acc),
    .wr_ptr    (wr_ptr),
    .wr_data   (wr_data),
    .rd_acc    (rd_acc),
    .rd_ptr    (rd_ptr),
    .rd_data   (rd_data)
  );

  spf_monitor #(.CNT_W(CNT_W), .THR_W(THR_W), .WM_W(WM_W)) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .width_sel (width_sel),
    .thresh    (thresh),
    .stop_cnt  (stop_cnt),
    .low_cnt   (low_cnt),
    .high_cnt  (high_cnt),
    .thr_evt   (thresh_evt),
    .wm_stop   (wm_stop),
    .wm_low    (wm_low),
    .wm_high   (wm_high)
  );

  assign status = {empty, full, count[PTR_W-1:0]};

  // R8: an event only appears while the level meets the threshold
  assert_evt_level_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    thresh_evt |-> (32'(count) >= 32'(thresh)));

  // R3 and R4: a refused access never coincides with an accepted one of the same kind
  assert_strobe_exclusive_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !overflow);

endmodule

// File: tb/spi_word_fifo_tb_top.sv
module spi_word_fifo_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_wr;
  logic [1:0]  op_cmd;
  logic [1:0]  width_sel;
  logic [7:0]  thresh;
  logic [5:0]  stop_cnt;
  logic [5:0]  low_cnt;
  logic [5:0]  high_cnt;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [31:0] rd_data;
  logic [9:0]  status;
  logic        overflow;
  logic        underflow;
  logic        thresh_evt;
  logic        wm_stop;
  logic        wm_low;
  logic        wm_high;

  always #10 clk = ~clk;

  spi_word_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_cmd(op_cmd),
    .width_sel(width_sel), .thresh(thresh), .stop_cnt(stop_cnt),
    .low_cnt(low_cnt), .high_cnt(high_cnt), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .status(status),
    .overflow(overflow), .underflow(underflow), .thresh_evt(thresh_evt),
    .wm_stop(wm_stop), .wm_low(wm_low), .wm_high(wm_high)
  );

  int          n_checks = 0;
  int          n_fail   = 0;
  int          evt_cnt  = 0;
  bit          m_run    = 1'b0;
  bit          mon_pop  = 1'b0;
  logic [31:0] sb[$];
  logic [31:0] last_rd  = '0;

  task automatic check(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic int m_depth();
    return 256 >> ((width_sel == 2'd3) ? 2 : int'(width_sel));
  endfunction

  function automatic logic [31:0] m_mask();
    case (width_sel)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [9:0] m_status();
    int n = sb.size();
    return {n == 0, n >= m_depth(), 8'(n)};
  endfunction

  task automatic do_op(input logic [1:0] cmd);
    op_wr = 1'b1; op_cmd = cmd;
    @(negedge clk);
    op_wr = 1'b0; op_cmd = 2'b00;
    if (cmd[0]) sb.delete();
    m_run = cmd[1];
  endtask

  task automatic push(input logic [31:0] d);
    bit acc;
    bit ovf_exp;
    acc = m_run && (sb.size() < m_depth());
    ovf_exp = m_run && !acc;
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (acc) sb.push_back(d & m_mask());
    if (overflow !== ovf_exp)
      check(1'b0, "R3 overflow strobe", 32'(overflow), 32'(ovf_exp));
  endtask

  task automatic pop();
    bit unf_exp;
    unf_exp = m_run && (sb.size() == 0);
    rd_en = 1'b1; mon_pop = m_run && (sb.size() > 0);
    @(negedge clk);
    rd_en = 1'b0; mon_pop = 1'b0;
    if (underflow !== unf_exp)
      check(1'b0, "R4 underflow strobe", 32'(underflow), 32'(unf_exp));
  endtask

  task automatic chk_status(input string what);
    check(status === m_status(), what, 32'(status), 32'(m_status()));
  endtask

  task automatic chk_wm(input string what);
    int q;
    q = (sb.size() << ((width_sel == 2'd3) ? 2 : int'(width_sel))) / 4;
    check({wm_stop, wm_low, wm_high} === {q >= int'(stop_cnt), q >= int'(low_cnt), q >= int'(high_cnt)},
          what, 32'({wm_stop, wm_low, wm_high}),
          32'({q >= int'(stop_cnt), q >= int'(low_cnt), q >= int'(high_cnt)}));
  endtask

  // scoreboard monitor: R2 ordering/masking and R10 one-cycle read latency
  always @(posedge clk) begin
    if (mon_pop) begin
      logic [31:0] exp;
      exp = sb.pop_front();
      #5;
      check(rd_data === exp, "R2 R10 read data", rd_data, exp);
      last_rd = exp;
    end
  end

  always @(negedge clk) if (rst_n && thresh_evt) evt_cnt++;

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; op_wr = 1'b0; op_cmd = 2'b00; width_sel = 2'd0;
    thresh = 8'd100; stop_cnt = 6'd5; low_cnt = 6'd6; high_cnt = 6'd2;
    wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check(status === 10'h200, "R11 status after reset", 32'(status), 32'h200);
    check(rd_data === 32'h0, "R11 rd_data after reset", rd_data, 32'h0);

    // R6 writes and reads while stopped have no effect
    push(32'h55);
    pop();
    check(status === 10'h200, "R6 stopped write ignored", 32'(status), 32'h200);

    // R5 start with clear; R7 level field; R2 byte masking
    do_op(2'b11);
    push(32'hAABBCC11); push(32'h22); push(32'h33);
    check(status === 10'h003, "R7 R10 level after three writes", 32'(status), 32'h003);
    pop(); pop(); pop();
    chk_status("R7 empty after drain");

    // R4 read from empty keeps last data and strobes
    pop();
    check(underflow === 1'b1, "R4 underflow strobe on empty read", 32'(underflow), 32'h1);
    check(rd_data === 32'h33, "R4 rd_data holds on underflow", rd_data, 32'h33);

    // R1 byte depth, R8 single threshold event
    evt_cnt = 0;
    for (int i = 0; i < 256; i++) push(32'h1234_5600 | 32'(i));
    check(status === 10'h100, "R1 R7 byte mode full at 256", 32'(status), 32'h100);
    check(evt_cnt == 1, "R8 one threshold event over fill", 32'(evt_cnt), 32'd1);
    chk_wm("R9 watermarks at byte full");

    // R3 write when full dropped
    push(32'hDEAD_BEEF);
    check(overflow === 1'b1, "R3 overflow strobe when full", 32'(overflow), 32'h1);
    check(status === 10'h100, "R3 level unchanged after drop", 32'(status), 32'h100);
    for (int i = 0; i < 256; i++) pop();
    chk_status("R2 empty after byte drain");

    // R5 R6 stop keeps contents, start without clear resumes
    push(32'h77); push(32'h88);
    do_op(2'b00);
    pop();
    push(32'h99);
    check(underflow === 1'b0, "R6 no underflow while stopped", 32'(underflow), 32'h0);
    check(status === 10'h002, "R6 level held while stopped", 32'(status), 32'h002);
    do_op(2'b10);
    check(status === 10'h002, "R5 start keeps contents", 32'(status), 32'h002);
    pop(); pop();

    // R9 halfword watermarks at exact field values
    width_sel = 2'd1;
    do_op(2'b11);
    for (int i = 0; i < 10; i++) push(32'hCAFE_0000 | 32'(i));
    chk_wm("R9 halfword Q=5");
    check({wm_stop, wm_low, wm_high} === 3'b101, "R9 stop and high set, low clear",
          32'({wm_stop, wm_low, wm_high}), 32'h5);
    push(32'hCAFE_0100); push(32'hCAFE_0101);
    check(wm_low === 1'b1, "R9 low set at Q=6", 32'(wm_low), 32'h1);
    for (int i = 12; i < 128; i++) push(32'hCAFE_0000 | 32'(i));
    check(status === 10'h180, "R1 halfword full at 128", 32'(status), 32'h180);
    for (int i = 0; i < 128; i++) pop();

    // R1 word depth for codes 2 and 3
    width_sel = 2'd2;
    do_op(2'b11);
    for (int i = 0; i < 64; i++) push(32'hF00D_0000 + 32'(i * 7));
    check(status === 10'h140, "R1 word full at 64", 32'(status), 32'h140);
    for (int i = 0; i < 64; i++) pop();
    width_sel = 2'd3;
    do_op(2'b11);
    for (int i = 0; i < 64; i++) push(32'hBEEF_0000 + 32'(i));
    check(status === 10'h140, "R1 code 3 acts as word", 32'(status), 32'h140);
    push(32'h1);
    check(overflow === 1'b1, "R3 overflow in word mode", 32'(overflow), 32'h1);

    // R5 clear-only command empties and stops
    do_op(2'b01);
    check(status === 10'h200, "R5 clear empties buffer", 32'(status), 32'h200);
    push(32'h42);
    check(status === 10'h200, "R5 clear also stops", 32'(status), 32'h200);

    @(negedge clk);
    summary();
  end

endmodule